// File: doc/BRIEF.md
# Pipelined Converter Bit-Weight Corrector

This block sits behind a pipelined converter core with fifteen stages, each resolving one raw decision bit per sample, and turns those bits into a 12-bit output code. The stages resolve the same sample one after another, so stage k delivers its bit for a given sample k cycles after stage 0 did. A triangular array of delay registers lines up all fifteen bits of one sample. The aligned bits then go through a two-cycle adder pipeline. That pipeline adds the stored weight of every bit that is set, plus an always-present offset weight, and then rounds and saturates the result.

The weights are 16-bit unsigned fixed-point numbers with four fractional bits. They live in a small register-file memory of sixteen words, where addresses 0 to 14 belong to stages 0 to 14 and address 15 holds the offset. All sixteen words are read in parallel in a single cycle, so each sample is weighted with one consistent snapshot of the memory. A new conversion may start on every clock.

Top module: `stage_err_corrector`

## Requirements
- R1: For a sample whose start strobe is sampled at edge E, the bit weighted for stage k is the value of raw bit k sampled at edge E+k.
- R2: The sum equals the weight at address 15 plus the weight at address k for every aligned stage bit k that is 1. Weights are unsigned, with 4 fractional bits.
- R3: The code equals (sum + 8) >> 4, so exactly half an LSB rounds up: an offset of 7 with no bits set gives 0, and an offset of 8 gives 1.
- R4: Any rounded value above 4095 is output as 4095. Offsets of 0xFFF7 and 0xFFF8 with no bits set both give 4095.
- R5: `code_valid` is 1 after edge E+17 for each start sampled at edge E, for exactly one cycle per start. Starts on consecutive edges give consecutive valid cycles.
- R6: In a cycle with no valid result, `code_valid` is 0 and `code` keeps its previous value.
- R7: A write with `cf_we`=1 stores `cf_wdata` at `cf_addr` on that edge. `cf_rdata` is registered: after an edge it shows the word at `cf_addr` as it was before that edge's write.
- R8: A write at edge W applies to every sample started at edge W-15 or later. Samples started earlier use the old word. A sample is never weighted with a mixture of old and new words.
- R9: Reset clears every weight to 0, and clears `code_valid`, `code` and `cf_rdata` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_start | input | 1 | Stage 0 bit of a new sample is present this cycle |
| raw_bits | input | 15 | Raw decision bits, bit k from stage k |
| cf_we | input | 1 | Weight memory write enable |
| cf_addr | input | 4 | Weight memory address (15 = offset) |
| cf_wdata | input | 16 | Weight write data |
| cf_rdata | output | 16 | Registered weight read data |
| code_valid | output | 1 | Output code valid strobe |
| code | output | 12 | Corrected, rounded and saturated output code |

## Verification
The hardest case to reach from the ports is a weight write that lands while a continuous stream of samples is in flight. In that case the cycle of the write decides, to the edge, which samples still see the old word. The stimulus makes random writes on random cycles against mostly back-to-back random samples. It also places directed offset writes inside an unbroken stream of all-zero samples, which lays the switch-over edge bare in the output codes. A bench model of the memory, advanced write by write, selects for each sample the snapshot that the write-timing rule names.

// File: rtl/ecorr_pkg.sv
// Shared sizing defaults for the bit-weight corrector.
package ecorr_pkg;
    localparam int unsigned STAGES_DEF = 15;  // raw decision bits per sample
    localparam int unsigned WGT_W_DEF  = 16;  // weight word width
    localparam int unsigned FRAC_W_DEF = 4;   // fractional bits in a weight
    localparam int unsigned CODE_W_DEF = 12;  // output code width
endpackage

// File: rtl/skew_align.sv
// Triangular delay array: lane k holds STAGES+1-k flops, so the bits of one
// sample all sit in the last flop of their lanes after start edge + STAGES.
module skew_align #(
    parameter int unsigned STAGES = ecorr_pkg::STAGES_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [STAGES-1:0] raw,
    output logic              al_vld,
    output logic [STAGES-1:0] al_bits
);
    localparam int unsigned TAG_D = STAGES + 1;

    logic [TAG_D-1:0] tag_q;

    for (genvar k = 0; k < STAGES; k++) begin : g_lane
        localparam int unsigned D = STAGES + 1 - k;
        logic [D-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[D-2:0], raw[k]};
        end
        assign al_bits[k] = chain_q[D-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tag_q <= '0;
        else        tag_q <= {tag_q[TAG_D-2:0], start};
    end
    assign al_vld = tag_q[TAG_D-1];

    // R1: the newest lane sees the raw bit sampled on the previous edge
    p_last_lane_r1: assert property (@(posedge clk) disable iff (!rst_n)
        g_lane[STAGES-1].chain_q[0] == $past(raw[STAGES-1]));
endmodule

// File: rtl/coef_bank.sv
// Register-file weight memory: one write port, one registered read port,
// and every word exposed in parallel for the adder pipeline.
module coef_bank #(
    parameter int unsigned DEPTH  = ecorr_pkg::STAGES_DEF + 1,
    parameter int unsigned WGT_W  = ecorr_pkg::WGT_W_DEF,
    parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [WGT_W-1:0]       wr_data,
    output logic [WGT_W-1:0]       rd_data,
    output logic [DEPTH*WGT_W-1:0] wgt_flat
);
    logic [WGT_W-1:0] mem_q [DEPTH];
    logic             in_range;

    assign in_range = (int'(addr) < DEPTH);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            rd_data <= '0;
        end else begin
            rd_data <= in_range ? mem_q[addr] : '0;  // value before this write
            if (wr_en && in_range) mem_q[addr] <= wr_data;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_flat
        assign wgt_flat[i*WGT_W +: WGT_W] = mem_q[i];
    end

    // R7: a write is visible in the addressed word on the following cycle
    p_write_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && in_range) |=> (mem_q[$past(addr)] == $past(wr_data)));
    // R7: with no write, the memory word read out does not change underneath
    p_word_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && in_range) |=> (mem_q[$past(addr)] == $past(mem_q[addr])));
endmodule

// File: rtl/wsum_pipe.sv
// Two-cycle weighted sum: stage A gates and adds two halves of the weight
// set, stage B joins them, rounds half up and saturates.
module wsum_pipe #(
    parameter int unsigned STAGES = ecorr_pkg::STAGES_DEF,
    parameter int unsigned WGT_W  = ecorr_pkg::WGT_W_DEF,
    parameter int unsigned FRAC_W = ecorr_pkg::FRAC_W_DEF,
    parameter int unsigned CODE_W = ecorr_pkg::CODE_W_DEF
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_vld,
    input  logic [STAGES-1:0]               in_bits,
    input  logic [(STAGES+1)*WGT_W-1:0]     wgt_flat,
    output logic                            out_vld,
    output logic [CODE_W-1:0]               out_code
);
    localparam int unsigned DEPTH = STAGES + 1;
    localparam int unsigned HALF  = DEPTH / 2;
    localparam int unsigned SUM_W = WGT_W + $clog2(DEPTH);
    localparam logic [SUM_W:0] RND   = (SUM_W+1)'(1) << (FRAC_W - 1);
    localparam logic [SUM_W:0] MAXV  = (SUM_W+1)'((1 << CODE_W) - 1);
    localparam logic [SUM_W:0] SAT_T = ((SUM_W+1)'(1) << (CODE_W + FRAC_W)) - RND;

    logic [DEPTH-1:0] sel;
    logic [SUM_W-1:0] lo_n, hi_n, lo_q, hi_q;
    logic             a_vld_q;
    logic [SUM_W:0]   tot, shr;
    logic [CODE_W-1:0] code_n;

    assign sel = {1'b1, in_bits};  // offset word always contributes

    always_comb begin
        lo_n = '0;
        hi_n = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (sel[i]) begin
                if (i < HALF) lo_n = lo_n + SUM_W'(wgt_flat[i*WGT_W +: WGT_W]);
                else          hi_n = hi_n + SUM_W'(wgt_flat[i*WGT_W +: WGT_W]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q    <= '0;
            hi_q    <= '0;
            a_vld_q <= 1'b0;
        end else begin
            a_vld_q <= in_vld;
            if (in_vld) begin
                lo_q <= lo_n;
                hi_q <= hi_n;
            end
        end
    end

    always_comb begin
        tot    = {1'b0, lo_q} + {1'b0, hi_q} + RND;
        shr    = tot >> FRAC_W;
        code_n = (shr > MAXV) ? '1 : shr[CODE_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_code <= '0;
        end else begin
            out_vld <= a_vld_q;
            if (a_vld_q) out_code <= code_n;
        end
    end

    // R5: a result leaves exactly two cycles after its aligned sample
    p_two_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> $past(in_vld, 2));
    // R6: without a result the code does not move
    p_code_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(a_vld_q) |-> $stable(out_code));
    // R4: a partial-sum total at or above the saturation point gives full scale
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(a_vld_q) && ($past({1'b0, lo_q} + {1'b0, hi_q}) >= SAT_T))
        |-> (out_code == '1));
endmodule

// File: rtl/stage_err_corrector.sv
// Top: skew alignment, weight memory and weighted-sum pipeline.
module stage_err_corrector #(
    parameter int unsigned STAGES = ecorr_pkg::STAGES_DEF,
    parameter int unsigned WGT_W  = ecorr_pkg::WGT_W_DEF,
    parameter int unsigned FRAC_W = ecorr_pkg::FRAC_W_DEF,
    parameter int unsigned CODE_W = ecorr_pkg::CODE_W_DEF,
    parameter int unsigned ADDR_W = $clog2(STAGES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_start,
    input  logic [STAGES-1:0] raw_bits,
    input  logic              cf_we,
    input  logic [ADDR_W-1:0] cf_addr,
    input  logic [WGT_W-1:0]  cf_wdata,
    output logic [WGT_W-1:0]  cf_rdata,
    output logic              code_valid,
    output logic [CODE_W-1:0] code
);
    localparam int unsigned DEPTH = STAGES + 1;

    logic                    al_vld;
    logic [STAGES-1:0]       al_bits;
    logic [DEPTH*WGT_W-1:0]  wgt_flat;

    skew_align #(.STAGES(STAGES)) u_align (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (smp_start),
        .raw     (raw_bits),
        .al_vld  (al_vld),
        .al_bits (al_bits)
    );

    coef_bank #(.DEPTH(DEPTH), .WGT_W(WGT_W), .ADDR_W(ADDR_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cf_we),
        .addr     (cf_addr),
        .wr_data  (cf_wdata),
        .rd_data  (cf_rdata),
        .wgt_flat (wgt_flat)
    );

    wsum_pipe #(.STAGES(STAGES), .WGT_W(WGT_W), .FRAC_W(FRAC_W),
                .CODE_W(CODE_W)) u_sum (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (al_vld),
        .in_bits  (al_bits),
        .wgt_flat (wgt_flat),
        .out_vld  (code_valid),
        .out_code (code)
    );

    // R9: the first cycle out of reset never carries a result
    p_quiet_after_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !code_valid);
endmodule

// File: tb/stage_err_corrector_test.sv
module stage_err_corrector_test;
    localparam int NC  = 3000;
    localparam int LAT = 17;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        smp_start;
    logic [14:0] raw_bits;
    logic        cf_we;
    logic [3:0]  cf_addr;
    logic [15:0] cf_wdata;
    logic [15:0] cf_rdata;
    logic        code_valid;
    logic [11:0] code;

    always #10 clk = ~clk;

    stage_err_corrector uut (
        .clk(clk), .rst_n(rst_n), .smp_start(smp_start), .raw_bits(raw_bits),
        .cf_we(cf_we), .cf_addr(cf_addr), .cf_wdata(cf_wdata),
        .cf_rdata(cf_rdata), .code_valid(code_valid), .code(code)
    );

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    logic [14:0] samp   [NC];
    bit          mark   [NC];
    logic [11:0] expc   [NC];
    logic [15:0] exp_rd [NC];
    logic [15:0] model  [16];
    logic [11:0] last_code;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R2 R3 R4: weighted sum, round half up, saturate
    function automatic logic [11:0] ref_code(input logic [14:0] b);
        int unsigned s;
        s = model[15];
        for (int k = 0; k < 15; k++) if (b[k]) s += model[k];
        s = (s + 8) >> 4;
        if (s > 4095) s = 4095;
        return s[11:0];
    endfunction

    function automatic string req_of(input int n0);
        if (n0 >= 180 && n0 < 600) return "R3 R4 R8";
        if (n0 >= 620 && n0 < 700) return "R2 R4";
        return "R1 R2 R8";
    endfunction

    initial begin
        void'($urandom(32'h1c0ffee));
        rst_n = 1'b0; smp_start = 1'b0; raw_bits = '0;
        cf_we = 1'b0; cf_addr = '0; cf_wdata = '0;
        for (int i = 0; i < 16; i++) model[i] = '0;
        for (int i = 0; i < NC; i++) begin mark[i] = 0; samp[i] = '0; end
        repeat (3) @(negedge clk);
        check(code_valid == 1'b0, "R9 valid", int'(code_valid), 0);
        check(code == '0, "R9 code", int'(code), 0);
        check(cf_rdata == '0, "R9 rdata", int'(cf_rdata), 0);
        rst_n = 1'b1;
        last_code = '0;
        for (int n = 0; n < NC; n++) begin
            int  wa;
            bit  we;
            logic [15:0] wd;
            // results of edge n-1
            if (n > 0) begin
                int n0;
                n0 = n - 1 - LAT;
                if (n0 >= 0 && mark[n0]) begin
                    check(code_valid == 1'b1, "R5 valid", int'(code_valid), 1);
                    check(code == expc[n0], req_of(n0), int'(code), int'(expc[n0]));
                end else begin
                    check(code_valid == 1'b0, "R5 R6 valid", int'(code_valid), 0);
                    check(code == last_code, "R6 hold", int'(code), int'(last_code));
                end
                last_code = code;
                check(cf_rdata == exp_rd[n-1], "R7 read", int'(cf_rdata), int'(exp_rd[n-1]));
            end
            // R8: sample started at n-16 uses words after writes through edge n-1
            if (n >= 16 && mark[n-16]) expc[n-16] = ref_code(samp[n-16]);
            // choose stimulus for edge n
            we = 0; wa = 0; wd = '0;
            if (n < 16) begin
                we = 1; wa = n;
                wd = (n < 12) ? 16'((2048 >> n) << 4) : 16'h0;
                samp[n] = 15'($urandom); mark[n] = ($urandom % 4) != 0;
            end else if (n >= 180 && n < 600) begin
                samp[n] = '0; mark[n] = 1;
                if (n == 200) begin we = 1; wa = 15; wd = 16'd7;      end
                if (n == 300) begin we = 1; wa = 15; wd = 16'd8;      end
                if (n == 400) begin we = 1; wa = 15; wd = 16'hFFF7;   end
                if (n == 500) begin we = 1; wa = 15; wd = 16'hFFF8;   end
            end else if (n >= 600 && n < 620) begin
                samp[n] = 15'($urandom); mark[n] = 0;
                if (n == 600) begin we = 1; wa = 15; wd = 16'd0; end
            end else if (n >= 620 && n < 700) begin
                samp[n] = (n % 2 == 0) ? 15'h7FFF : 15'($urandom); mark[n] = 1;
            end else if (n < NC - 40) begin
                samp[n] = 15'($urandom); mark[n] = ($urandom % 4) != 0;
                if (($urandom % 16) == 0) begin
                    we = 1; wa = int'($urandom % 16); wd = 16'($urandom % 8192);
                end
            end else begin
                samp[n] = '0; mark[n] = 0;
            end
            smp_start = mark[n];
            for (int k = 0; k < 15; k++) raw_bits[k] = (n - k >= 0) ? samp[n-k][k] : 1'b0;
            cf_we    = we;
            cf_addr  = we ? 4'(wa) : 4'($urandom % 16);
            cf_wdata = wd;
            exp_rd[n] = model[cf_addr];  // R7 read-before-write
            if (we) model[wa] = wd;
            @(negedge clk);
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual %0d expected %0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule